// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request port and a cache controller. It keeps a record of every memory request in flight, keyed by the cache-line address. Requests that may modify a line go into one small associative table, and pure reads go into a second one. Each new request gets an answer in the same cycle. The request can be accepted. It can be refused because its line is already in flight. It can be refused because the tracker is full. Or it can be rejected because it is malformed. An accepted request is stored with its issue time. One cycle later it is forwarded to the cache controller, tagged with the hit latency of the cache it targets.

A response names a line and a class (read or write). It retires the matching entry from the table of that class. One cycle later it produces a completion carrying the response word and the measured latency. A response whose line is missing from its table raises a sticky protocol-error flag, and no tracker state changes. A periodic watchdog inspects the age of every entry and raises a sticky deadlock flag when any entry has waited too long. Four counters classify alias refusals by the class of the entry that blocked the request and the kind of the new request.

Top module: `mreq_tracker`

## Requirements
- R1: Request kinds are coded load=0, fetch=1, store=2, rmw-read=3, rmw-write=4, locked-read=5, locked-write=6, and 7 is reserved. Kinds 2 to 6 occupy the write table and are retired only by a response with `rsp_is_write`=1. Kinds 0 and 1 occupy the read table and are retired only by a response with `rsp_is_write`=0. The line address is the request address with its low log2(BLOCK_BYTES) bits removed.
- R2: `req_status` is combinational and takes the first matching case in this priority order: reject (3); the line is in the write table, aliased (1); the line is in the read table, aliased (1); the outstanding total is at or above MAX_OUT, full (2); otherwise ready (0). A request is accepted only when `req_valid` is high and the status is ready.
- R3: A request is rejected when its kind is 7, or when the byte offset within the line plus `req_len` exceeds BLOCK_BYTES. A request whose offset plus length is exactly BLOCK_BYTES is accepted.
- R4: When an aliased request hits the write table, `alias_wr_by_rd` increments if the new kind is load, fetch or rmw-read. Otherwise `alias_wr_by_wr` increments.
- R5: When an aliased request hits the read table only, `alias_rd_by_wr` increments if the new kind is store or rmw-write. Otherwise `alias_rd_by_rd` increments.
- R6: One cycle after acceptance, `fwd_valid` pulses with the line and the kind. `fwd_lat` is ICACHE_LAT for a fetch and DCACHE_LAT for every other kind.
- R7: A response that finds its line in its own class table removes the entry and lowers `outstanding` by one. One cycle later `done_valid` pulses with the response word and with latency equal to the response cycle minus the issue cycle, modulo 2^TS_W.
- R8: `done_lat_valid` is high with a completion only when the reported latency is nonzero.
- R9: A response whose line is not in its class table sets `proto_err`, which stays set until reset. No entry is removed and no completion is produced.
- R10: `outstanding` always equals the combined occupancy of both tables and never exceeds MAX_OUT.
- R11: The watchdog arms on an insertion when it is idle and expires DEADLOCK_CYC cycles later. If any entry is then at least DEADLOCK_CYC cycles old, `deadlock` sets and stays set until reset.
- R12: On expiry the watchdog re-arms for another DEADLOCK_CYC cycles if any request remains outstanding. Otherwise it goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New request present |
| req_kind | input | 3 | Request kind code (R1) |
| req_addr | input | ADDR_W | Byte address of request |
| req_len | input | log2(BLOCK_BYTES)+1 | Access length in bytes |
| req_status | output | 2 | Answer: 0 ready, 1 aliased, 2 full, 3 reject |
| fwd_valid | output | 1 | Request forwarded to cache controller |
| fwd_line | output | ADDR_W-log2(BLOCK_BYTES) | Line address of forwarded request |
| fwd_kind | output | 3 | Kind of forwarded request |
| fwd_lat | output | LAT_W | Cache hit latency for forwarded request |
| rsp_valid | input | 1 | Response present |
| rsp_is_write | input | 1 | Response retires a write-table entry |
| rsp_line | input | ADDR_W-log2(BLOCK_BYTES) | Line address of response |
| rsp_data | input | DATA_W | Response word |
| done_valid | output | 1 | Completion pulse |
| done_is_write | output | 1 | Class of completed request |
| done_data | output | DATA_W | Response word passed through |
| done_latency | output | TS_W | Measured latency |
| done_lat_valid | output | 1 | Latency is nonzero |
| outstanding | output | log2(MAX_OUT+1) | Requests in flight |
| deadlock | output | 1 | Sticky watchdog error |
| proto_err | output | 1 | Sticky unmatched-response error |
| alias_wr_by_rd | output | STAT_W | Read-like request blocked by write entry |
| alias_wr_by_wr | output | STAT_W | Write-like request blocked by write entry |
| alias_rd_by_wr | output | STAT_W | Store or rmw-write blocked by read entry |
| alias_rd_by_rd | output | STAT_W | Other request blocked by read entry |

## Verification
The bench fills the tracker and then sends one request to a line already in flight and one to a fresh line. An implementation that checked capacity before aliasing would answer full to both, and one that dropped the capacity check would overfill a table. Requests with a different offset in a live line, with an offset plus length exactly at the block size and one byte past it, and with the reserved kind probe the line masking and the size check. An off-by-one comparison would accept or reject the wrong boundary case. A locked read retired by a write response, and a store answered by a read response, reveal a misrouted class: the first would wrongly raise the error flag, and the second would wrongly retire the entry. The watchdog is tested with an entry inserted after the watchdog armed. That entry is young at the first expiry and only becomes old at the re-armed expiry, so a watchdog that never re-arms, or that uses the wrong age test, misses the deadlock. Its response arrives exactly 2^TS_W cycles after issue, so a design that reports a zero latency would show up.

// File: rtl/mreq_pkg.sv
// Shared kind and status codes for the outstanding request tracker.
// Assumes a 3-bit kind and a 2-bit status on the request port.
package mreq_pkg;

    typedef enum logic [2:0] {
        K_LOAD    = 3'd0,
        K_IFETCH  = 3'd1,
        K_STORE   = 3'd2,
        K_RMW_RD  = 3'd3,
        K_RMW_WR  = 3'd4,
        K_LOCK_RD = 3'd5,
        K_LOCK_WR = 3'd6,
        K_RSVD    = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_ALIASED = 2'd1,
        ST_FULL    = 2'd2,
        ST_REJECT  = 2'd3
    } req_status_e;

    // Kinds that may modify the line live in the write table.
    function automatic logic kind_is_write_class(input logic [2:0] k);
        return (k >= 3'd2) && (k <= 3'd6);
    endfunction

    // Kinds that only consume data, for the write-table alias split.
    function automatic logic kind_reads_only(input logic [2:0] k);
        return (k == K_LOAD) || (k == K_IFETCH) || (k == K_RMW_RD);
    endfunction

    // Kinds that produce data, for the read-table alias split.
    function automatic logic kind_stores(input logic [2:0] k);
        return (k == K_STORE) || (k == K_RMW_WR);
    endfunction

endpackage

// File: rtl/mreq_line_cam.sv
// Small associative table of in-flight requests keyed by line address.
// Each entry holds a valid bit, the line and the issue timestamp.
// Assumes that the caller never inserts a line that is already present
// and never inserts when the table is full.
module mreq_line_cam #(
    parameter int ENTRIES   = 8,
    parameter int LINE_W    = 26,
    parameter int TS_W      = 24,
    parameter int AGE_LIMIT = 1000,
    parameter int OCC_W     = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    input  logic              ins_en,
    input  logic [LINE_W-1:0] ins_line,
    input  logic              rm_en,
    input  logic [LINE_W-1:0] rm_line,
    output logic              rm_hit,
    output logic [TS_W-1:0]   rm_ts,
    output logic [OCC_W-1:0]  occ,
    output logic              any_aged
);
    localparam logic [TS_W-1:0] AGE_L = TS_W'(AGE_LIMIT);

    logic [ENTRIES-1:0] vld;
    logic [LINE_W-1:0]  e_line [ENTRIES];
    logic [TS_W-1:0]    e_ts   [ENTRIES];
    logic [ENTRIES-1:0] m_lk, m_rm, aged, free_oh;

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
            // Per-entry match and age comparators.
            assign m_lk[gi] = vld[gi] && (e_line[gi] == lk_line);
            assign m_rm[gi] = vld[gi] && (e_line[gi] == rm_line);
            assign aged[gi] = vld[gi] && ((now - e_ts[gi]) >= AGE_L);

            // Entry storage: remove on matching response, fill on insert.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld[gi]    <= 1'b0;
                    e_line[gi] <= '0;
                    e_ts[gi]   <= '0;
                end else if (rm_en && m_rm[gi]) begin
                    vld[gi] <= 1'b0;
                end else if (ins_en && free_oh[gi]) begin
                    vld[gi]    <= 1'b1;
                    e_line[gi] <= ins_line;
                    e_ts[gi]   <= now;
                end
            end
        end
    endgenerate

    // Lowest free slot as a one-hot vector.
    always_comb begin
        logic found;
        found   = 1'b0;
        free_oh = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!vld[i] && !found) begin
                free_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    // Timestamp of the entry matched by the response.
    always_comb begin
        rm_ts = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_rm[i]) rm_ts = rm_ts | e_ts[i];
        end
    end

    // Occupancy count of valid entries.
    always_comb begin
        occ = '0;
        for (int i = 0; i < ENTRIES; i++) occ = occ + OCC_W'(vld[i]);
    end

    assign lk_hit   = |m_lk;
    assign rm_hit   = |m_rm;
    assign any_aged = |aged;

endmodule

// File: rtl/mreq_watchdog.sv
// Periodic age watchdog. It arms on an insertion when idle and expires
// THRESH cycles later. On expiry it latches deadlock if any entry is old,
// then re-arms while requests remain outstanding.
// Assumes pending_next reflects occupancy after the current cycle.
module mreq_watchdog #(
    parameter int THRESH = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ins_fire,
    input  logic any_aged,
    input  logic pending_next,
    output logic deadlock
);
    localparam int TMR_W = $clog2(THRESH + 1);
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(THRESH - 1);

    logic             armed;
    logic [TMR_W-1:0] timer;
    logic             expire;

    assign expire = armed && (timer == '0);

    // Arm, count down, inspect on expiry, re-arm or go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            timer    <= '0;
            deadlock <= 1'b0;
        end else if (expire) begin
            deadlock <= deadlock | any_aged;
            if (pending_next) timer <= RELOAD;
            else              armed <= 1'b0;
        end else if (armed) begin
            timer <= timer - 1'b1;
        end else if (ins_fire) begin
            armed <= 1'b1;
            timer <= RELOAD;
        end
    end

endmodule

// File: rtl/mreq_alias_stats.sv
// Four wrapping counters that classify alias refusals by the table hit
// and the kind of the refused request.
// Assumes alias_evt is high only for a request answered as aliased.
module mreq_alias_stats
    import mreq_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alias_evt,
    input  logic              hit_wr_tbl,
    input  logic [2:0]        kind,
    output logic [STAT_W-1:0] wr_by_rd,
    output logic [STAT_W-1:0] wr_by_wr,
    output logic [STAT_W-1:0] rd_by_wr,
    output logic [STAT_W-1:0] rd_by_rd
);
    // Bump exactly one counter per alias refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_by_rd <= '0;
            wr_by_wr <= '0;
            rd_by_wr <= '0;
            rd_by_rd <= '0;
        end else if (alias_evt) begin
            if (hit_wr_tbl) begin
                if (kind_reads_only(kind)) wr_by_rd <= wr_by_rd + 1'b1;
                else                       wr_by_wr <= wr_by_wr + 1'b1;
            end else begin
                if (kind_stores(kind))     rd_by_wr <= rd_by_wr + 1'b1;
                else                       rd_by_rd <= rd_by_rd + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mreq_tracker.sv
// Outstanding memory request tracker. It answers each request with
// ready, aliased, full or reject, keeps write-class and read-class
// requests in separate line tables, forwards accepted requests with
// the target cache latency, retires entries on responses with a
// latency report, and watches entry ages for deadlock.
// Assumes at most one request and one response per cycle.
module mreq_tracker
    import mreq_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int BLOCK_BYTES  = 64,
    parameter int MAX_OUT      = 8,
    parameter int TS_W         = 24,
    parameter int DEADLOCK_CYC = 500000,
    parameter int ICACHE_LAT   = 1,
    parameter int DCACHE_LAT   = 2,
    parameter int LAT_W        = 4,
    parameter int DATA_W       = 64,
    parameter int STAT_W       = 16,
    localparam int OFF_W       = $clog2(BLOCK_BYTES),
    localparam int LINE_W      = ADDR_W - OFF_W,
    localparam int LEN_W       = OFF_W + 1,
    localparam int CNT_W       = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic [1:0]        req_status,
    output logic              fwd_valid,
    output logic [LINE_W-1:0] fwd_line,
    output logic [2:0]        fwd_kind,
    output logic [LAT_W-1:0]  fwd_lat,
    input  logic              rsp_valid,
    input  logic              rsp_is_write,
    input  logic [LINE_W-1:0] rsp_line,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              done_valid,
    output logic              done_is_write,
    output logic [DATA_W-1:0] done_data,
    output logic [TS_W-1:0]   done_latency,
    output logic              done_lat_valid,
    output logic [CNT_W-1:0]  outstanding,
    output logic              deadlock,
    output logic              proto_err,
    output logic [STAT_W-1:0] alias_wr_by_rd,
    output logic [STAT_W-1:0] alias_wr_by_wr,
    output logic [STAT_W-1:0] alias_rd_by_wr,
    output logic [STAT_W-1:0] alias_rd_by_rd
);
    localparam logic [LEN_W:0]   BLK_LIMIT = (LEN_W + 1)'(BLOCK_BYTES);
    localparam logic [CNT_W:0]   MAX_TOTAL = (CNT_W + 1)'(MAX_OUT);

    logic [TS_W-1:0]   now;
    logic [LINE_W-1:0] req_line;
    logic [OFF_W-1:0]  req_off;
    logic              size_bad, kind_bad, is_wr_kind;
    req_status_e       status;
    logic              accept, wr_ins, rd_ins;
    logic              w_lk_hit, r_lk_hit, w_rm_hit, r_rm_hit;
    logic [TS_W-1:0]   w_rm_ts, r_rm_ts, hit_ts, lat_now;
    logic [CNT_W-1:0]  w_occ, r_occ;
    logic [CNT_W:0]    occ_total;
    logic              w_aged, r_aged;
    logic              rsp_hit, retire;
    logic [CNT_W-1:0]  cnt_next;

    assign req_line   = req_addr[ADDR_W-1:OFF_W];
    assign req_off    = req_addr[OFF_W-1:0];
    assign size_bad   = ({2'b00, req_off} + {1'b0, req_len}) > BLK_LIMIT;
    assign kind_bad   = (req_kind == K_RSVD);
    assign is_wr_kind = kind_is_write_class(req_kind);
    assign occ_total  = {1'b0, w_occ} + {1'b0, r_occ};

    // Free-running time base for issue stamps and latency.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    // Priority answer for the presented request.
    always_comb begin
        if (kind_bad || size_bad)     status = ST_REJECT;
        else if (w_lk_hit)            status = ST_ALIASED;
        else if (r_lk_hit)            status = ST_ALIASED;
        else if (occ_total >= MAX_TOTAL) status = ST_FULL;
        else                          status = ST_READY;
    end

    assign req_status = status;
    assign accept     = req_valid && (status == ST_READY);
    assign wr_ins     = accept && is_wr_kind;
    assign rd_ins     = accept && !is_wr_kind;

    mreq_line_cam #(
        .ENTRIES(MAX_OUT), .LINE_W(LINE_W), .TS_W(TS_W),
        .AGE_LIMIT(DEADLOCK_CYC), .OCC_W(CNT_W)
    ) u_wr_cam (
        .clk(clk), .rst_n(rst_n), .now(now),
        .lk_line(req_line), .lk_hit(w_lk_hit),
        .ins_en(wr_ins), .ins_line(req_line),
        .rm_en(rsp_valid && rsp_is_write), .rm_line(rsp_line),
        .rm_hit(w_rm_hit), .rm_ts(w_rm_ts),
        .occ(w_occ), .any_aged(w_aged)
    );

    mreq_line_cam #(
        .ENTRIES(MAX_OUT), .LINE_W(LINE_W), .TS_W(TS_W),
        .AGE_LIMIT(DEADLOCK_CYC), .OCC_W(CNT_W)
    ) u_rd_cam (
        .clk(clk), .rst_n(rst_n), .now(now),
        .lk_line(req_line), .lk_hit(r_lk_hit),
        .ins_en(rd_ins), .ins_line(req_line),
        .rm_en(rsp_valid && !rsp_is_write), .rm_line(rsp_line),
        .rm_hit(r_rm_hit), .rm_ts(r_rm_ts),
        .occ(r_occ), .any_aged(r_aged)
    );

    assign rsp_hit  = rsp_is_write ? w_rm_hit : r_rm_hit;
    assign hit_ts   = rsp_is_write ? w_rm_ts  : r_rm_ts;
    assign retire   = rsp_valid && rsp_hit;
    assign lat_now  = now - hit_ts;
    assign cnt_next = outstanding + CNT_W'(accept) - CNT_W'(retire);

    // Outstanding counter and sticky unmatched-response flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
            proto_err   <= 1'b0;
        end else begin
            outstanding <= cnt_next;
            if (rsp_valid && !rsp_hit) proto_err <= 1'b1;
        end
    end

    // Forward accepted request to the cache controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_line  <= '0;
            fwd_kind  <= '0;
            fwd_lat   <= '0;
        end else begin
            fwd_valid <= accept;
            if (accept) begin
                fwd_line <= req_line;
                fwd_kind <= req_kind;
                fwd_lat  <= (req_kind == K_IFETCH) ? LAT_W'(ICACHE_LAT)
                                                   : LAT_W'(DCACHE_LAT);
            end
        end
    end

    // Completion with pass-through data and measured latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid     <= 1'b0;
            done_is_write  <= 1'b0;
            done_data      <= '0;
            done_latency   <= '0;
            done_lat_valid <= 1'b0;
        end else begin
            done_valid <= retire;
            if (retire) begin
                done_is_write  <= rsp_is_write;
                done_data      <= rsp_data;
                done_latency   <= lat_now;
                done_lat_valid <= (lat_now != '0);
            end
        end
    end

    mreq_watchdog #(
        .THRESH(DEADLOCK_CYC)
    ) u_wdog (
        .clk(clk), .rst_n(rst_n),
        .ins_fire(accept),
        .any_aged(w_aged || r_aged),
        .pending_next(cnt_next != '0),
        .deadlock(deadlock)
    );

    mreq_alias_stats #(
        .STAT_W(STAT_W)
    ) u_stats (
        .clk(clk), .rst_n(rst_n),
        .alias_evt(req_valid && (status == ST_ALIASED)),
        .hit_wr_tbl(w_lk_hit),
        .kind(req_kind),
        .wr_by_rd(alias_wr_by_rd),
        .wr_by_wr(alias_wr_by_wr),
        .rd_by_wr(alias_rd_by_wr),
        .rd_by_rd(alias_rd_by_rd)
    );

endmodule

// File: rtl/mreq_tracker_chk.sv
// Property checker for the outstanding request tracker, bound to the top.
// Assumes the status encoding of the package.
module mreq_tracker_chk #(
    parameter int MAX_OUT = 8,
    parameter int CNT_W   = 4,
    parameter int TS_W    = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_kind,
    input logic [1:0]       req_status,
    input logic             fwd_valid,
    input logic             done_valid,
    input logic [TS_W-1:0]  done_latency,
    input logic             done_lat_valid,
    input logic [CNT_W-1:0] outstanding,
    input logic [CNT_W-1:0] occ_w,
    input logic [CNT_W-1:0] occ_r,
    input logic             deadlock,
    input logic             proto_err
);
    a_r10_count_matches_tables: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, outstanding} == ({1'b0, occ_w} + {1'b0, occ_r})));

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding <= CNT_W'(MAX_OUT)));

    a_r2_full_never_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (outstanding >= CNT_W'(MAX_OUT))) |-> (req_status != 2'd0));

    a_r3_reserved_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 3'd7)) |-> (req_status == 2'd3));

    a_r6_forward_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_status == 2'd0)) |=> fwd_valid);

    a_r8_zero_latency_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_lat_valid == (done_latency != '0)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    a_r11_deadlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> deadlock);

endmodule

bind mreq_tracker mreq_tracker_chk #(
    .MAX_OUT(MAX_OUT), .CNT_W(CNT_W), .TS_W(TS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_status(req_status), .fwd_valid(fwd_valid), .done_valid(done_valid),
    .done_latency(done_latency), .done_lat_valid(done_lat_valid),
    .outstanding(outstanding), .occ_w(w_occ), .occ_r(r_occ),
    .deadlock(deadlock), .proto_err(proto_err)
);

// File: tb/mreq_tracker_test.sv
// Directed bench for the outstanding request tracker.
module mreq_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_addr = '0;
    logic [6:0]  req_len = '0;
    logic [1:0]  req_status;
    logic        fwd_valid;
    logic [9:0]  fwd_line;
    logic [2:0]  fwd_kind;
    logic [3:0]  fwd_lat;
    logic        rsp_valid = 1'b0;
    logic        rsp_is_write = 1'b0;
    logic [9:0]  rsp_line = '0;
    logic [31:0] rsp_data = '0;
    logic        done_valid, done_is_write, done_lat_valid;
    logic [31:0] done_data;
    logic [5:0]  done_latency;
    logic [2:0]  outstanding;
    logic        deadlock, proto_err;
    logic [7:0]  s_wbr, s_wbw, s_rbw, s_rbr;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int e_wbr = 0, e_wbw = 0, e_rbw = 0, e_rbr = 0;

    mreq_tracker #(
        .ADDR_W(16), .BLOCK_BYTES(64), .MAX_OUT(4), .TS_W(6),
        .DEADLOCK_CYC(40), .ICACHE_LAT(2), .DCACHE_LAT(3), .LAT_W(4),
        .DATA_W(32), .STAT_W(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .req_status(req_status),
        .fwd_valid(fwd_valid), .fwd_line(fwd_line), .fwd_kind(fwd_kind),
        .fwd_lat(fwd_lat), .rsp_valid(rsp_valid), .rsp_is_write(rsp_is_write),
        .rsp_line(rsp_line), .rsp_data(rsp_data), .done_valid(done_valid),
        .done_is_write(done_is_write), .done_data(done_data),
        .done_latency(done_latency), .done_lat_valid(done_lat_valid),
        .outstanding(outstanding), .deadlock(deadlock), .proto_err(proto_err),
        .alias_wr_by_rd(s_wbr), .alias_wr_by_wr(s_wbw),
        .alias_rd_by_wr(s_rbw), .alias_rd_by_rd(s_rbr)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_stats(input string tag);
        chk({tag, " wr_by_rd"}, 64'(s_wbr), 64'(e_wbr));
        chk({tag, " wr_by_wr"}, 64'(s_wbw), 64'(e_wbw));
        chk({tag, " rd_by_wr"}, 64'(s_rbw), 64'(e_rbw));
        chk({tag, " rd_by_rd"}, 64'(s_rbr), 64'(e_rbr));
    endtask

    // Present one request; check status now and forward one cycle later.
    task automatic send(input logic [2:0] k, input int line, input int off,
                        input int len, input logic [1:0] exp, input string tag,
                        output int t);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = 16'(line * 64 + off);
        req_len   = 7'(len);
        #1;
        chk({tag, " status"}, 64'(req_status), 64'(exp));
        t = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " fwd_valid"}, 64'(fwd_valid), 64'(exp == 2'd0));
        if (exp == 2'd0) begin
            chk({tag, " fwd_line"}, 64'(fwd_line), 64'(line));
            chk({tag, " fwd_kind"}, 64'(fwd_kind), 64'(k));
            chk({tag, " fwd_lat R6"}, 64'(fwd_lat), (k == 3'd1) ? 64'd2 : 64'd3);
        end
    endtask

    // Present one response; check completion or error one cycle later.
    task automatic respond(input logic w, input int line, input logic [31:0] d,
                           input logic hit, input int t, input string tag);
        int u;
        int lat;
        @(negedge clk);
        rsp_valid    = 1'b1;
        rsp_is_write = w;
        rsp_line     = 10'(line);
        rsp_data     = d;
        u = cyc;
        @(negedge clk);
        rsp_valid = 1'b0;
        lat = (u - t) & 63;
        chk({tag, " done_valid"}, 64'(done_valid), 64'(hit));
        if (hit) begin
            chk({tag, " done_data R7"}, 64'(done_data), 64'(d));
            chk({tag, " done_is_write"}, 64'(done_is_write), 64'(w));
            chk({tag, " done_latency R7"}, 64'(done_latency), 64'(lat));
            chk({tag, " done_lat_valid R8"}, 64'(done_lat_valid), 64'(lat != 0));
        end else begin
            chk({tag, " proto_err R9"}, 64'(proto_err), 64'd1);
        end
    endtask

    task automatic t_reset;
        chk("reset outstanding", 64'(outstanding), 64'd0);
        chk("reset fwd_valid", 64'(fwd_valid), 64'd0);
        chk("reset done_valid", 64'(done_valid), 64'd0);
        chk("reset deadlock", 64'(deadlock), 64'd0);
        chk("reset proto_err", 64'(proto_err), 64'd0);
        chk_stats("reset");
    endtask

    task automatic t_basic;
        int t;
        send(3'd0, 4, 0, 8, 2'd0, "R2 load ready", t);
        chk("R10 count after load", 64'(outstanding), 64'd1);
        repeat (3) @(negedge clk);
        respond(1'b0, 4, 32'hABCD_0001, 1'b1, t, "R1 load retire");
        chk("R7 count after retire", 64'(outstanding), 64'd0);
        send(3'd1, 5, 16, 4, 2'd0, "R6 fetch ready", t);
        respond(1'b0, 5, 32'h1234_5678, 1'b1, t, "R1 fetch retire");
    endtask

    task automatic t_write_alias;
        int t, x;
        send(3'd2, 5, 0, 8, 2'd0, "R1 store ready", t);
        send(3'd0, 5, 32, 4, 2'd1, "R4 load on store", x);
        e_wbr++;
        send(3'd6, 5, 0, 4, 2'd1, "R4 locked write on store", x);
        e_wbw++;
        chk_stats("R4");
        respond(1'b1, 5, 32'h0000_0055, 1'b1, t, "R1 store retire");
    endtask

    task automatic t_read_alias;
        int t, x;
        send(3'd0, 6, 0, 8, 2'd0, "R2 load ready", t);
        send(3'd2, 6, 8, 8, 2'd1, "R5 store on load", x);
        e_rbw++;
        send(3'd4, 6, 0, 8, 2'd1, "R5 rmw write on load", x);
        e_rbw++;
        send(3'd1, 6, 0, 4, 2'd1, "R5 fetch on load", x);
        e_rbr++;
        send(3'd3, 6, 0, 4, 2'd1, "R5 rmw read on load", x);
        e_rbr++;
        chk_stats("R5");
        respond(1'b0, 6, 32'h0000_0066, 1'b1, t, "R7 load retire");
    endtask

    task automatic t_full;
        int ta, tb, tc, td, x;
        send(3'd0, 10, 0, 8, 2'd0, "R2 fill a", ta);
        send(3'd0, 11, 0, 8, 2'd0, "R2 fill b", tb);
        send(3'd2, 12, 0, 8, 2'd0, "R2 fill c", tc);
        send(3'd5, 13, 0, 8, 2'd0, "R2 fill d", td);
        chk("R10 count full", 64'(outstanding), 64'd4);
        send(3'd0, 10, 4, 4, 2'd1, "R2 alias beats full", x);
        e_rbr++;
        send(3'd2, 12, 0, 4, 2'd1, "R2 write alias beats full", x);
        e_wbw++;
        send(3'd0, 20, 0, 8, 2'd2, "R2 full", x);
        send(3'd0, 20, 0, 65, 2'd3, "R3 reject beats full", x);
        chk("R10 count unchanged", 64'(outstanding), 64'd4);
        chk_stats("R2 full");
        respond(1'b0, 10, 32'hA, 1'b1, ta, "R7 retire a");
        respond(1'b0, 11, 32'hB, 1'b1, tb, "R7 retire b");
        respond(1'b1, 12, 32'hC, 1'b1, tc, "R1 retire c");
        respond(1'b1, 13, 32'hD, 1'b1, td, "R1 locked read via write");
        chk("R10 count drained", 64'(outstanding), 64'd0);
    endtask

    task automatic t_size;
        int t, x;
        send(3'd0, 8, 56, 8, 2'd0, "R3 exact block end", t);
        send(3'd2, 9, 57, 8, 2'd3, "R3 one past block end", x);
        send(3'd7, 9, 0, 4, 2'd3, "R3 reserved kind", x);
        chk("R3 count after rejects", 64'(outstanding), 64'd1);
        respond(1'b0, 8, 32'h8, 1'b1, t, "R7 retire boundary");
    endtask

    task automatic t_proto;
        int t;
        chk("R9 no error yet", 64'(proto_err), 64'd0);
        send(3'd2, 7, 0, 8, 2'd0, "R9 store", t);
        respond(1'b0, 7, 32'h77, 1'b0, t, "R9 R1 read rsp to store");
        chk("R9 count kept", 64'(outstanding), 64'd1);
        respond(1'b1, 7, 32'h78, 1'b1, t, "R9 write rsp after error");
        chk("R9 error sticky", 64'(proto_err), 64'd1);
    endtask

    task automatic t_watchdog;
        int ta, tb;
        repeat (90) @(negedge clk);
        chk("R11 no deadlock so far", 64'(deadlock), 64'd0);
        send(3'd0, 1, 0, 8, 2'd0, "R11 arm", ta);
        respond(1'b0, 1, 32'h1, 1'b1, ta, "R11 quick retire");
        while (cyc < ta + 30) @(negedge clk);
        send(3'd0, 2, 0, 8, 2'd0, "R12 late insert", tb);
        while (cyc < ta + 70) @(negedge clk);
        chk("R11 young entry at first expiry", 64'(deadlock), 64'd0);
        while (cyc < ta + 85) @(negedge clk);
        chk("R12 re-armed expiry flags old entry", 64'(deadlock), 64'd1);
        while (cyc < tb + 63) @(negedge clk);
        respond(1'b0, 2, 32'hFEED, 1'b1, tb, "R8 wrap to zero latency");
        chk("R8 zero latency value", 64'(done_latency), 64'd0);
        chk("R11 deadlock sticky", 64'(deadlock), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_write_alias();
        t_read_alias();
        t_full();
        t_size();
        t_proto();
        t_watchdog();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired before bench completed");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule